// File: doc/BRIEF.md
# Paged Instruction Address Sequencer

This block keeps the fetch address of a small byte-oriented processor. The address is split into a page number in the upper bits and an offset within the page in the lower bits. As instructions are fetched, the sequencer adds the instruction length (one or two bytes) to the offset only. The offset wraps inside its page and never carries into the page number. A separate page-step command moves execution to the following page.

Jump, call and return targets enter through a full-width load port, which replaces the whole address. Decoding, program memory and any rules on where targets may point belong to the surrounding logic. The current address is the block's only output. Software has no other access to it.

Top module: `pgpc_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fetch_addr` is 0.
- R2: With `step_en`=1 and no load, the offset field (`fetch_addr[7:0]`) grows by `step_two`?2:1 modulo 256 on the next clock. The page field (`fetch_addr[13:8]`) does not change.
- R3: An offset of 255 stepped by 1 becomes 0, and an offset of 254 or 255 stepped by 2 becomes 0 or 1, with the page unchanged.
- R4: `page_adv`=1 with no load adds one to the page field on the next clock. If `step_en` is not also set, the offset stays as it was.
- R5: The page field wraps from 63 to 0.
- R6: When `page_adv` and `step_en` are both set, the page field and the offset field each advance in the same clock.
- R7: `load_en`=1 replaces all 14 address bits with `load_addr` on the next clock. This takes priority over a step or page advance in the same cycle.
- R8: `hold`=1 leaves the address unchanged, whatever the other inputs are. Hold outranks load.
- R9: With no strobes set, the address keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freeze the address |
| step_en | input | 1 | Advance the offset by the instruction length |
| step_two | input | 1 | Instruction length: 0 means one byte, 1 means two bytes |
| page_adv | input | 1 | Advance the page field |
| load_en | input | 1 | Load a full target address |
| load_addr | input | 14 | Target address |
| fetch_addr | output | 14 | Current fetch address |

## Verification
The bench uses the default widths: a 6-bit page and an 8-bit offset. With these widths, both the offset wrap at 255 and the page wrap at 63 can be reached with directed loads followed by short runs. A random phase then mixes every strobe together, so each priority combination occurs many times. A behavioural integer model is compared against the output on every clock.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
    typedef enum logic [1:0] {
        ACT_KEEP,
        ACT_LOAD,
        ACT_SEQ
    } act_e;
endpackage

// File: rtl/pgpc_offset.sv
module pgpc_offset #(
    parameter int OFS_W = 8
) (
    input  logic [OFS_W-1:0] ofs_q,
    input  logic             step_en,
    input  logic             step_two,
    output logic [OFS_W-1:0] ofs_next
);
    logic [OFS_W-1:0] inc;
    always_comb begin
        inc = step_two ? OFS_W'(2) : OFS_W'(1);
        ofs_next = step_en ? ofs_q + inc : ofs_q;
    end
endmodule

// File: rtl/pgpc_page.sv
module pgpc_page #(
    parameter int PG_W = 6
) (
    input  logic [PG_W-1:0] pg_q,
    input  logic            adv,
    output logic [PG_W-1:0] pg_next
);
    always_comb pg_next = adv ? pg_q + PG_W'(1) : pg_q;
endmodule

// File: rtl/pgpc_top.sv
module pgpc_top
    import pgpc_pkg::*;
#(
    parameter int PG_W  = 6,
    parameter int OFS_W = 8,
    localparam int AW   = PG_W + OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          step_en,
    input  logic          step_two,
    input  logic          page_adv,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] fetch_addr
);
    typedef struct packed {
        logic [PG_W-1:0]  pg;
        logic [OFS_W-1:0] ofs;
    } addr_t;

    addr_t a_q, a_d;
    act_e act;
    logic [OFS_W-1:0] ofs_seq;
    logic [PG_W-1:0]  pg_seq;

    pgpc_offset #(.OFS_W(OFS_W)) u_ofs (
        .ofs_q(a_q.ofs), .step_en(step_en), .step_two(step_two), .ofs_next(ofs_seq)
    );
    pgpc_page #(.PG_W(PG_W)) u_pg (
        .pg_q(a_q.pg), .adv(page_adv), .pg_next(pg_seq)
    );

    always_comb begin
        if (hold)         act = ACT_KEEP;
        else if (load_en) act = ACT_LOAD;
        else              act = ACT_SEQ;
        a_d = a_q;
        case (act)
            ACT_LOAD: a_d = addr_t'(load_addr);
            ACT_SEQ:  begin a_d.pg = pg_seq; a_d.ofs = ofs_seq; end
            default:  a_d = a_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) a_q <= '0;
        else     a_q <= a_d;
    end

    assign fetch_addr = a_q;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> fetch_addr == '0); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(fetch_addr)); // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) (!hold && load_en) |=> fetch_addr == $past(load_addr)); // R7
    AST_SEQ_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load_en && !page_adv) |=> fetch_addr[AW-1:OFS_W] == $past(fetch_addr[AW-1:OFS_W])); // R2
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load_en && !page_adv && !step_en) |=> $stable(fetch_addr)); // R9
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load_en && page_adv) |=> fetch_addr[AW-1:OFS_W] == PG_W'($past(fetch_addr[AW-1:OFS_W]) + 1'b1)); // R4
endmodule

// File: tb/sim_pgpc_top.sv
`timescale 1ns/1ps
module sim_pgpc_top;
    logic clk = 0, rst = 1, hold = 0, step_en = 0, step_two = 0, page_adv = 0, load_en = 0;
    logic [13:0] load_addr = 0;
    logic [13:0] fetch_addr;
    int total = 0, bad = 0, model = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pgpc_top u0 (.clk, .rst, .hold, .step_en, .step_two, .page_adv, .load_en, .load_addr, .fetch_addr);

    task automatic chk(input string req, input int exp);
        total++;
        if (fetch_addr !== 14'(exp)) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, fetch_addr, 14'(exp));
        end
    endtask

    // behavioural model update, applied at each edge
    function automatic int nxt(input int cur);
        int pg = cur / 256, of = cur % 256;
        if (rst) return 0;
        if (hold) return cur;
        if (load_en) return load_addr;
        if (step_en) of = (of + (step_two ? 2 : 1)) % 256;
        if (page_adv) pg = (pg + 1) % 64;
        return pg * 256 + of;
    endfunction

    always @(posedge clk) begin
        model <= nxt(model);
        cyc <= cyc + 1;
    end

    task automatic cyc1(input string req, input bit h, input bit s, input bit t,
                        input bit p, input bit l, input int la);
        hold = h; step_en = s; step_two = t; page_adv = p; load_en = l; load_addr = 14'(la);
        @(posedge clk); #1;
        chk(req, model);
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1; chk("R1", 0);
        rst = 0;
        @(posedge clk); #1; chk("R1", 0);
        cyc1("R2", 0,1,0,0,0,0); chk("R2", 14'h0001);
        cyc1("R2", 0,1,1,0,0,0); chk("R2", 14'h0003);
        cyc1("R9", 0,0,0,0,0,0); chk("R9", 14'h0003);
        cyc1("R7", 0,1,1,1,1,14'h12FF); chk("R7", 14'h12FF);
        cyc1("R3", 0,1,0,0,0,0); chk("R3", 14'h1200);
        cyc1("R7", 0,0,0,0,1,14'h05FE);
        cyc1("R3", 0,1,1,0,0,0); chk("R3", 14'h0500);
        cyc1("R7", 0,0,0,0,1,14'h05FF);
        cyc1("R3", 0,1,1,0,0,0); chk("R3", 14'h0501);
        cyc1("R4", 0,0,0,1,0,0); chk("R4", 14'h0601);
        cyc1("R6", 0,1,1,1,0,0); chk("R6", 14'h0703);
        cyc1("R7", 0,0,0,0,1,14'h3F80);
        cyc1("R5", 0,0,0,1,0,0); chk("R5", 14'h0080);
        cyc1("R8", 1,1,1,1,1,14'h1111); chk("R8", 14'h0080);
        cyc1("R8", 1,1,0,0,0,0); chk("R8", 14'h0080);
        for (int i = 0; i < 3000; i++) begin
            cyc1("R2 R4 R7 R8 mixed", ($urandom%8)==0, $urandom%2, $urandom%2,
                 ($urandom%4)==0, ($urandom%6)==0, $urandom);
        end
        rst = 1;
        @(posedge clk); #1; chk("R1", 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule